// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the clock driven to a memory card from the master clock of the host controller. One configuration word, loaded through a plain write port, selects the division ratio and several switches:

- a master enable;
- a power-save gate that stops the clock while the command and data paths are both idle;
- a bypass that forwards the master clock unchanged;
- an inversion option for the bypass path;
- a flow-control stall that freezes the clock while the data FIFO is not ready;
- a bus-width code that is passed to the data path.

A parameter chooses one of two division laws. The first law gives a symmetric clock at master/(2·(N+1)). The second gives master/(N+2), with the high half rounded up.

Next to the clock, the block provides a rise strobe and a fall strobe. Each is one master cycle long. The command and data paths use them to launch and sample bits without a second clock domain. A stall or a power-save gate only stretches the current half period. A new divider value is applied at a rising edge, so no runt pulse can appear on the card clock.

Top module: `card_clk_gen`

## Requirements
- R1: During and after reset, with nothing written, the card clock is low, both strobes are low and the bus-width output is 00.
- R2: With division law 0, enable (bit 8) set and divider N (bits 7:0), the card clock period is 2·(N+1) master cycles and its high part lasts N+1 cycles.
- R3: With division law 1, the period is N+2 master cycles and the high part lasts (N+2)-floor((N+2)/2) cycles.
- R4: The largest divider, 255, gives a period of 512 master cycles under law 0 and 257 under law 1.
- R5: While the enable bit 8 is clear, the card clock stays low and no strobe is produced.
- R6: With bypass (bit 10) and enable set, the card clock follows the master clock, and both strobes are high in every cycle.
- R7: The inversion bit 11 makes the bypassed card clock the inverse of the master clock under law 1. Under law 0 this bit is ignored.
- R8: With flow control (bit 12) set and fifo_ready_i low, the card clock level is held and no strobe appears; clocking resumes when fifo_ready_i rises. With bit 12 clear, fifo_ready_i has no effect.
- R9: With power save (bit 9) set, the card clock is held while cmd_busy_i and dat_busy_i are both low. It runs while either of them is high.
- R10: A divider written while the clock runs takes effect at the next rising edge. The period in progress completes with the old value.
- R11: In divided mode, the rise strobe marks exactly the first master cycle in which the card clock is high. The fall strobe marks the first cycle in which it is low. The two strobes are never high together, and each period holds exactly one fall strobe.
- R12: Bits 14:13 appear on bus_width_o one cycle after the write (00 one lane, 01 four lanes, 10 eight lanes).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_wdata_i | input | DIV_W+7 | configuration word |
| cmd_busy_i | input | 1 | command path active |
| dat_busy_i | input | 1 | data path active |
| fifo_ready_i | input | 1 | data FIFO can accept or supply a word |
| card_clk_o | output | 1 | clock to the card |
| rise_stb_o | output | 1 | first master cycle of card clock high |
| fall_stb_o | output | 1 | first master cycle of card clock low |
| bus_width_o | output | 2 | data bus width code |

## Verification
The hardest case to reach is a divider rewrite that lands in the middle of a running period. Showing that the old period still completes needs the write to be aligned with a rising edge. The bench therefore waits for a rise strobe, issues the write in that same cycle and counts master cycles to the next rise. It then measures the following period for the new value. Stalls are brought about by first loading the flow-control or power-save switch while the clock runs, and only then dropping fifo_ready_i or both busy inputs. This is followed by a window in which the level must hold. Random dividers are applied to a law-0 instance and a law-1 instance side by side.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
    localparam int FLAG_W = 7;

    typedef enum logic [1:0] {
        WIDTH_1 = 2'b00,
        WIDTH_4 = 2'b01,
        WIDTH_8 = 2'b10
    } ccg_width_e;

    // switch fields sitting just above the divider field
    typedef struct packed {
        logic [1:0] width;
        logic       hwfc;
        logic       neg;
        logic       bypass;
        logic       pwrsave;
        logic       en;
    } ccg_flags_t;
endpackage

// File: rtl/ccg_cfg_reg.sv
module ccg_cfg_reg
    import ccg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    cfg_we_i,
    input  logic [DIV_W+FLAG_W-1:0] cfg_wdata_i,
    output logic [DIV_W-1:0]        div_o,
    output ccg_flags_t              flags_o
);
    localparam int CFG_W = DIV_W + FLAG_W;

    typedef struct packed {
        logic [CFG_W-1:0] word;
    } cfg_st_t;

    cfg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_we_i) s_d.word = cfg_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign div_o   = s_q.word[DIV_W-1:0];
    assign flags_o = ccg_flags_t'(s_q.word[CFG_W-1:DIV_W]);

    a_r12_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> ({flags_o, div_o} == $past(cfg_wdata_i)));
endmodule

// File: rtl/ccg_run_gate.sv
module ccg_run_gate
    import ccg_pkg::*;
(
    input  ccg_flags_t flags_i,
    input  logic       cmd_busy_i,
    input  logic       dat_busy_i,
    input  logic       fifo_ready_i,
    output logic       run_o
);
    logic idle_gate, fifo_gate;

    always_comb begin
        idle_gate = flags_i.pwrsave && !cmd_busy_i && !dat_busy_i;
        fifo_gate = flags_i.hwfc && !fifo_ready_i;
        run_o     = !idle_gate && !fifo_gate;
    end
endmodule

// File: rtl/ccg_divider.sv
module ccg_divider #(
    parameter int DIV_W   = 8,
    parameter int DIV_LAW = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             lvl_o,
    output logic             rise_o,
    output logic             fall_o
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic             lvl;
        logic             rise;
        logic             fall;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t s_d, s_q;
    logic [CNT_W-1:0] half_len;

    generate
        if (DIV_LAW == 0) begin : g_sym
            assign half_len = {1'b0, s_q.div} + CNT_W'(1);
        end else begin : g_plus2
            logic [CNT_W-1:0] span;
            assign span     = {1'b0, s_q.div} + CNT_W'(2);
            assign half_len = s_q.lvl ? (span - (span >> 1)) : (span >> 1);
        end
    endgenerate

    always_comb begin
        s_d      = s_q;
        s_d.rise = 1'b0;
        s_d.fall = 1'b0;
        if (!en_i) begin
            s_d.lvl = 1'b0;
            s_d.cnt = '0;
            s_d.div = div_i;
        end else if (run_i) begin
            if (s_q.cnt == half_len - CNT_W'(1)) begin
                s_d.cnt = '0;
                s_d.lvl = !s_q.lvl;
                if (!s_q.lvl) begin
                    s_d.rise = 1'b1;
                    s_d.div  = div_i;   // new ratio only at a rising edge
                end else begin
                    s_d.fall = 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign lvl_o  = s_q.lvl;
    assign rise_o = s_q.rise;
    assign fall_o = s_q.fall;

    a_r11_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(s_q.rise && s_q.fall));
    a_r11_rise_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.rise |-> (s_q.lvl && !$past(s_q.lvl)));
    a_r8_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !run_i) |=> $stable(s_q.lvl));
    a_r5_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!s_q.lvl && !s_q.rise && !s_q.fall));
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
    import ccg_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_LAW = 0
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    cfg_we_i,
    input  logic [DIV_W+FLAG_W-1:0] cfg_wdata_i,
    input  logic                    cmd_busy_i,
    input  logic                    dat_busy_i,
    input  logic                    fifo_ready_i,
    output logic                    card_clk_o,
    output logic                    rise_stb_o,
    output logic                    fall_stb_o,
    output logic [1:0]              bus_width_o
);
    logic [DIV_W-1:0] div;
    ccg_flags_t       flags;
    logic             run, div_en, lvl, rise, fall, bypass_run, neg_sel;

    ccg_cfg_reg #(.DIV_W(DIV_W)) i_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_we_i    (cfg_we_i),
        .cfg_wdata_i (cfg_wdata_i),
        .div_o       (div),
        .flags_o     (flags)
    );

    ccg_run_gate i_gate (
        .flags_i      (flags),
        .cmd_busy_i   (cmd_busy_i),
        .dat_busy_i   (dat_busy_i),
        .fifo_ready_i (fifo_ready_i),
        .run_o        (run)
    );

    assign div_en = flags.en && !flags.bypass;

    ccg_divider #(.DIV_W(DIV_W), .DIV_LAW(DIV_LAW)) i_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (div_en),
        .run_i  (run),
        .div_i  (div),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    generate
        if (DIV_LAW == 1) begin : g_neg
            assign neg_sel = flags.neg;
        end else begin : g_noneg
            assign neg_sel = 1'b0;
        end
    endgenerate

    assign bypass_run  = flags.en && flags.bypass && run;
    assign card_clk_o  = bypass_run ? (clk_i ^ neg_sel) : lvl;
    assign rise_stb_o  = bypass_run || rise;
    assign fall_stb_o  = bypass_run || fall;
    assign bus_width_o = flags.width;
endmodule

// File: tb/test_card_clk_gen.sv
module test_card_clk_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int CFG_W      = DIV_W + 7;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic cmd_busy = 1'b0, dat_busy = 1'b0, fifo_ready = 1'b1;
    logic ck[2], rs[2], fs[2];
    logic [1:0] bw0, bw1;
    int errors = 0, checks = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_clk_gen #(.DIV_W(DIV_W), .DIV_LAW(0)) i_card_clk_gen (
        .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
        .cmd_busy_i(cmd_busy), .dat_busy_i(dat_busy), .fifo_ready_i(fifo_ready),
        .card_clk_o(ck[0]), .rise_stb_o(rs[0]), .fall_stb_o(fs[0]), .bus_width_o(bw0));

    card_clk_gen #(.DIV_W(DIV_W), .DIV_LAW(1)) i_card_clk_gen_alt (
        .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
        .cmd_busy_i(cmd_busy), .dat_busy_i(dat_busy), .fifo_ready_i(fifo_ready),
        .card_clk_o(ck[1]), .rise_stb_o(rs[1]), .fall_stb_o(fs[1]), .bus_width_o(bw1));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [CFG_W-1:0] mk(int div, bit en, bit ps, bit byp,
                                             bit neg, bit hwfc, logic [1:0] w);
        return {w, hwfc, neg, byp, ps, en, 8'(div)};
    endfunction

    function automatic int exp_per(int law, int n);
        return (law == 0) ? 2 * (n + 1) : n + 2;
    endfunction

    function automatic int exp_hi(int law, int n);
        return (law == 0) ? n + 1 : (n + 2) - ((n + 2) / 2);
    endfunction

    task automatic wr(logic [CFG_W-1:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_rise(int k, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rs[k]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic measure(int k, string req, int eper, int ehi);
        bit ok;
        int per, hi, falls;
        wait_rise(k, ok);
        chk({req, " rise seen"}, int'(ok), 1);
        chk("R11 level high at rise strobe", int'(ck[k]), 1);
        per = 1; hi = 1; falls = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rs[k]) break;
            per++;
            hi += int'(ck[k]);
            falls += int'(fs[k]);
        end
        chk({req, " period"}, per, eper);
        chk({req, " high part"}, hi, ehi);
        chk("R11 one fall per period", falls, 1);
    endtask

    task automatic freeze_chk(int k, string req);
        logic l0;
        int bad = 0;
        @(negedge clk);
        l0 = ck[k];
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rs[k] || fs[k] || ck[k] != l0) bad++;
        end
        chk(req, bad, 0);
    endtask

    initial begin
        bit ok;
        int n, d;
        void'($urandom(32'h5eed_c10c));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 clock low in reset", int'(ck[0]) + int'(ck[1]), 0);
        rst_ni = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 strobes low after reset", int'(rs[0]|fs[0]|rs[1]|fs[1]), 0);
        chk("R1 bus width zero", int'(bw0), 0);

        // R2 / R3 directed small dividers
        wr(mk(0, 1, 0, 0, 0, 0, 2'b00));
        measure(0, "R2 n=0", exp_per(0, 0), exp_hi(0, 0));
        measure(1, "R3 n=0", exp_per(1, 0), exp_hi(1, 0));
        wr(mk(3, 1, 0, 0, 0, 0, 2'b00));
        measure(0, "R2 n=3", 8, 4);
        measure(1, "R3 n=3", 5, 3);

        // R4 largest divider
        wr(mk(255, 1, 0, 0, 0, 0, 2'b00));
        measure(0, "R4 law0 n=255", 512, 256);
        measure(1, "R4 law1 n=255", 257, 129);

        // R10 divider change aligned to a rising edge
        wr(mk(3, 1, 0, 0, 0, 0, 2'b00));
        measure(0, "R10 old setup", 8, 4);
        wait_rise(0, ok);
        cfg_we = 1'b1; cfg_wdata = mk(6, 1, 0, 0, 0, 0, 2'b00);
        n = 1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (rs[0]) break;
            n++;
        end
        chk("R10 running period keeps old ratio", n, 8);
        measure(0, "R10 next period new ratio", 14, 7);

        // R8 flow-control stall
        wr(mk(1, 1, 0, 0, 0, 1, 2'b00));
        measure(0, "R8 running with fifo ready", 4, 2);
        @(negedge clk); fifo_ready = 1'b0;
        freeze_chk(0, "R8 stall holds law0");
        freeze_chk(1, "R8 stall holds law1");
        @(negedge clk); fifo_ready = 1'b1;
        measure(0, "R8 resume", 4, 2);
        wr(mk(1, 1, 0, 0, 0, 0, 2'b00));
        @(negedge clk); fifo_ready = 1'b0;
        measure(0, "R8 fifo ignored when off", 4, 2);
        @(negedge clk); fifo_ready = 1'b1;

        // R9 power save
        dat_busy = 1'b1;
        wr(mk(2, 1, 1, 0, 0, 0, 2'b00));
        measure(0, "R9 runs with data busy", 6, 3);
        @(negedge clk); dat_busy = 1'b0;
        freeze_chk(0, "R9 idle gates clock");
        @(negedge clk); cmd_busy = 1'b1;
        measure(0, "R9 runs with cmd busy", 6, 3);
        @(negedge clk); cmd_busy = 1'b0;

        // R5 enable off
        wr(mk(2, 0, 0, 0, 0, 0, 2'b00));
        d = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            d += int'(ck[0] | rs[0] | fs[0] | ck[1] | rs[1] | fs[1]);
        end
        chk("R5 disabled clock silent", d, 0);

        // R6 / R7 bypass
        wr(mk(5, 1, 0, 1, 1, 0, 2'b00));
        @(posedge clk); #1;
        chk("R6 bypass follows master high", int'(ck[0]), 1);
        chk("R7 law1 inverted high phase", int'(ck[1]), 0);
        @(negedge clk); #1;
        chk("R6 bypass follows master low", int'(ck[0]), 0);
        chk("R7 law1 inverted low phase", int'(ck[1]), 1);
        chk("R6 both strobes high", int'(rs[0] & fs[0] & rs[1] & fs[1]), 1);
        wr(mk(5, 1, 0, 1, 0, 0, 2'b00));
        @(posedge clk); #1;
        chk("R7 law1 not inverted when bit clear", int'(ck[1]), 1);

        // R12 bus width
        wr(mk(1, 1, 0, 0, 0, 0, 2'b01));
        chk("R12 four lanes", int'(bw0), 1);
        wr(mk(1, 1, 0, 0, 0, 0, 2'b10));
        chk("R12 eight lanes", int'(bw1), 2);

        // random dividers on both laws
        for (int r = 0; r < 12; r++) begin
            d = int'($urandom_range(0, 20));
            wr(mk(d, 1, 0, 0, 0, 0, 2'(r % 3)));
            chk("R12 random width", int'(bw0), r % 3);
            measure(0, "R2 random", exp_per(0, d), exp_hi(0, d));
            measure(1, "R3 random", exp_per(1, d), exp_hi(1, d));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule